// File: doc/BRIEF.md
# Cross-Domain Configuration Update Tracker

This block carries three configuration values (a prescaler, a reload count and an optional window count) from a fast register-bus clock domain into a slow, free-running low-speed oscillator domain. Software writes a value through a simple register port. The block latches the value in a bus-side holding register and starts a toggle handshake into the slow domain. A busy flag in a read-only status word stays set until the slow domain has taken the value and its acknowledge has come back.

Each value has its own channel. A channel accepts a new write only while its flag is clear, so software polls the status word before it writes a value again. Writes to different values can be in flight at the same time. The window channel exists only when the `HAS_WINDOW` parameter is 1.

Each domain has its own asynchronous active-low reset input. Each reset is released synchronously to its own clock inside the block.

Top module: `cfg_update_tracker`

## Requirements
- R1: After reset, the status word reads 0. The slow-domain prescaler output is 0, and the reload and window outputs are all ones (0xFFF).
- R2: The status word is read-only at byte offset 0x0C. Bit 0 is the prescaler busy flag, bit 1 is the reload busy flag, bit 2 is the window busy flag, and bits 31:3 read 0. A read of any other offset returns 0, and a write to 0x0C changes nothing.
- R3: Value offsets are 0x00 for the prescaler (data bits 2:0), 0x04 for reload (bits 11:0) and 0x08 for window (bits 11:0). An accepted write sets the matching busy flag from the next bus clock edge. A write to any other offset sets no flag.
- R4: When a busy flag clears, the slow-domain output equals the written value truncated to the field width. The flag clears within 5 slow clock periods of the write.
- R5: A write to a value whose busy flag is set is ignored. The value that was in flight is the one applied, and a later write issued after the flag clears is accepted.
- R6: The three channels work independently. Writes on consecutive bus cycles to all three values leave all three flags set together, and each output receives its own value.
- R7: With `HAS_WINDOW` = 0, status bit 2 always reads 0, a window write sets no flag, and the window output stays at 0xFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register-bus clock |
| bus_arst_n | input | 1 | Bus-domain asynchronous active-low reset |
| lsi_clk | input | 1 | Slow oscillator clock |
| lsi_arst_n | input | 1 | Slow-domain asynchronous active-low reset |
| reg_addr | input | ADDR_W (8) | Byte offset of the access |
| reg_wr | input | 1 | Write strobe, one bus cycle per write |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Combinational read data for reg_addr |
| lsi_presc | output | PRE_W (3) | Prescaler value in the slow domain |
| lsi_reload | output | RLD_W (12) | Reload value in the slow domain |
| lsi_window | output | WIN_W (12) | Window value in the slow domain |

## Verification
The prescaler channel is swept over all eight codes. The reload and window channels are each driven with walking ones, walking zeros, both extremes and an arithmetic stride of values. These patterns show that every output bit travels to its own position, with no stuck, swapped or truncated bit. A second write issued while the first is still in flight shows whether the gating works: a design that wrongly accepts the write would apply the newer value. Back-to-back writes to all three offsets separate independent channels from channels that share a flag or a holding register. A second instance built without the window channel shows that bit 2 and the window output stay fixed while the other two channels still work.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  localparam int unsigned OFS_PRESC  = 32'h00;
  localparam int unsigned OFS_RELOAD = 32'h04;
  localparam int unsigned OFS_WINDOW = 32'h08;
  localparam int unsigned OFS_STATUS = 32'h0C;

  localparam int unsigned STAT_PRESC  = 0;
  localparam int unsigned STAT_RELOAD = 1;
  localparam int unsigned STAT_WINDOW = 2;
  localparam int unsigned STAT_BITS   = 3;
endpackage

// File: rtl/cfgx_rst_sync.sv
module cfgx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/cfgx_bit_sync.sv
module cfgx_bit_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;
  logic [STAGES-1:0] ff_d;

  always_comb begin
    ff_d = {ff_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= {STAGES{RST_VAL}};
    else        ff_q <= ff_d;
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/cfgx_chan.sv
module cfgx_chan #(
  parameter int unsigned     W        = 12,
  parameter logic [W-1:0]    RST_VAL  = '1,
  parameter int unsigned     SYNC_STG = 2
) (
  input  logic         bus_clk,
  input  logic         bus_rst_n,
  input  logic         wr_hit_i,
  input  logic [W-1:0] wdata_i,
  output logic         busy_o,
  input  logic         lsi_clk,
  input  logic         lsi_rst_n,
  output logic [W-1:0] val_o
);
  // ---------------- bus domain ----------------
  logic         req_q, req_d;
  logic [W-1:0] hold_q, hold_d;
  logic         ack_bus;
  logic         accept;

  logic         ack_q, ack_d;

  cfgx_bit_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b0)) u_ack_sync (
    .clk   (bus_clk),
    .rst_n (bus_rst_n),
    .d_i   (ack_q),
    .q_o   (ack_bus)
  );

  assign busy_o = req_q ^ ack_bus;
  assign accept = wr_hit_i & ~busy_o;

  always_comb begin
    req_d  = req_q;
    hold_d = hold_q;
    if (accept) begin
      req_d  = ~req_q;
      hold_d = wdata_i;
    end
  end

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      req_q  <= 1'b0;
      hold_q <= RST_VAL;
    end else begin
      req_q  <= req_d;
      hold_q <= hold_d;
    end
  end

  // ---------------- slow domain ----------------
  logic         req_lsi;
  logic         capture;
  logic [W-1:0] val_q, val_d;

  cfgx_bit_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b0)) u_req_sync (
    .clk   (lsi_clk),
    .rst_n (lsi_rst_n),
    .d_i   (req_q),
    .q_o   (req_lsi)
  );

  assign capture = req_lsi ^ ack_q;

  always_comb begin
    ack_d = ack_q;
    val_d = val_q;
    if (capture) begin
      ack_d = req_lsi;
      val_d = hold_q;
    end
  end

  always_ff @(posedge lsi_clk or negedge lsi_rst_n) begin
    if (!lsi_rst_n) begin
      ack_q <= 1'b0;
      val_q <= RST_VAL;
    end else begin
      ack_q <= ack_d;
      val_q <= val_d;
    end
  end

  assign val_o = val_q;

  // ---------------- assertions ----------------
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    accept |=> busy_o); // R3

  AST_IGNORE_WHILE_BUSY: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (wr_hit_i && busy_o) |=> $stable(hold_q)); // R5

  AST_HOLD_STABLE_AT_FALL: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    $fell(busy_o) |-> $stable(hold_q)); // R4

  AST_HOLD_STABLE_AT_CAPTURE: assert property (@(posedge lsi_clk) disable iff (!lsi_rst_n)
    capture |-> $stable(hold_q)); // R4
endmodule

// File: rtl/cfg_update_tracker.sv
module cfg_update_tracker #(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned PRE_W      = 3,
  parameter int unsigned RLD_W      = 12,
  parameter int unsigned WIN_W      = 12,
  parameter int unsigned SYNC_STG   = 2,
  parameter bit          HAS_WINDOW = 1'b1
) (
  input  logic              bus_clk,
  input  logic              bus_arst_n,
  input  logic              lsi_clk,
  input  logic              lsi_arst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [PRE_W-1:0]  lsi_presc,
  output logic [RLD_W-1:0]  lsi_reload,
  output logic [WIN_W-1:0]  lsi_window
);
  import cfgx_pkg::*;

  localparam int unsigned FMAX_A = (PRE_W > RLD_W) ? PRE_W : RLD_W;
  localparam int unsigned FMAX   = (FMAX_A > WIN_W) ? FMAX_A : WIN_W;

  logic bus_rst_n;
  logic lsi_rst_n;

  cfgx_rst_sync #(.STAGES(2)) u_bus_rst (
    .clk (bus_clk), .arst_n (bus_arst_n), .rst_n_o (bus_rst_n)
  );
  cfgx_rst_sync #(.STAGES(2)) u_lsi_rst (
    .clk (lsi_clk), .arst_n (lsi_arst_n), .rst_n_o (lsi_rst_n)
  );

  // address decode
  logic hit_pre, hit_rld, hit_win, sel_stat;
  assign hit_pre  = reg_wr & (reg_addr == OFS_PRESC[ADDR_W-1:0]);
  assign hit_rld  = reg_wr & (reg_addr == OFS_RELOAD[ADDR_W-1:0]);
  assign hit_win  = reg_wr & (reg_addr == OFS_WINDOW[ADDR_W-1:0]);
  assign sel_stat = (reg_addr == OFS_STATUS[ADDR_W-1:0]);

  logic [STAT_BITS-1:0] busy_vec;

  cfgx_chan #(.W(PRE_W), .RST_VAL('0), .SYNC_STG(SYNC_STG)) u_pre (
    .bus_clk   (bus_clk),
    .bus_rst_n (bus_rst_n),
    .wr_hit_i  (hit_pre),
    .wdata_i   (reg_wdata[PRE_W-1:0]),
    .busy_o    (busy_vec[STAT_PRESC]),
    .lsi_clk   (lsi_clk),
    .lsi_rst_n (lsi_rst_n),
    .val_o     (lsi_presc)
  );

  cfgx_chan #(.W(RLD_W), .RST_VAL('1), .SYNC_STG(SYNC_STG)) u_rld (
    .bus_clk   (bus_clk),
    .bus_rst_n (bus_rst_n),
    .wr_hit_i  (hit_rld),
    .wdata_i   (reg_wdata[RLD_W-1:0]),
    .busy_o    (busy_vec[STAT_RELOAD]),
    .lsi_clk   (lsi_clk),
    .lsi_rst_n (lsi_rst_n),
    .val_o     (lsi_reload)
  );

  generate
    if (HAS_WINDOW) begin : g_win
      cfgx_chan #(.W(WIN_W), .RST_VAL('1), .SYNC_STG(SYNC_STG)) u_win (
        .bus_clk   (bus_clk),
        .bus_rst_n (bus_rst_n),
        .wr_hit_i  (hit_win),
        .wdata_i   (reg_wdata[WIN_W-1:0]),
        .busy_o    (busy_vec[STAT_WINDOW]),
        .lsi_clk   (lsi_clk),
        .lsi_rst_n (lsi_rst_n),
        .val_o     (lsi_window)
      );
    end else begin : g_nowin
      assign busy_vec[STAT_WINDOW] = 1'b0;
      assign lsi_window            = '1;
    end
  endgenerate

  // bits of the write port that no field uses
  logic unused_wr_bits;
  assign unused_wr_bits = ^{reg_wdata[DATA_W-1:FMAX], hit_win};

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (sel_stat) reg_rdata[STAT_BITS-1:0] = busy_vec;
  end

  AST_RSVD_ZERO: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    reg_rdata[DATA_W-1:STAT_BITS] == '0); // R2

  AST_WIN_FLAG_ABSENT: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    !HAS_WINDOW |-> (reg_rdata[STAT_WINDOW] == 1'b0)); // R7
endmodule

// File: tb/sim_cfg_update_tracker.sv
module sim_cfg_update_tracker;
  logic bus_clk = 1'b0;
  logic lsi_clk = 1'b0;
  always #5   bus_clk = ~bus_clk;   // 100 MHz
  always #125 lsi_clk = ~lsi_clk;   // slow clock, 25 bus cycles per period

  localparam int SLOW_LIMIT = 5 * 25;

  logic        bus_arst_n, lsi_arst_n;
  logic [7:0]  reg_addr;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] rd0, rd1;
  logic [2:0]  pre0, pre1;
  logic [11:0] rld0, rld1, win0, win1;

  cfg_update_tracker #(.HAS_WINDOW(1'b1)) u0 (
    .bus_clk(bus_clk), .bus_arst_n(bus_arst_n), .lsi_clk(lsi_clk), .lsi_arst_n(lsi_arst_n),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(rd0),
    .lsi_presc(pre0), .lsi_reload(rld0), .lsi_window(win0));

  cfg_update_tracker #(.HAS_WINDOW(1'b0)) u1 (
    .bus_clk(bus_clk), .bus_arst_n(bus_arst_n), .lsi_clk(lsi_clk), .lsi_arst_n(lsi_arst_n),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(rd1),
    .lsi_presc(pre1), .lsi_reload(rld1), .lsi_window(win1));

  int vecs = 0;
  int errs = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge bus_clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge bus_clk);
    reg_wr = 1'b0; reg_addr = 8'h0C;
    #1;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    reg_addr = 8'h0C;
    #1;
    while (((rd0[2:0] != 3'b000) || (rd1[2:0] != 3'b000)) && n < 400) begin
      @(negedge bus_clk); #1;
      n++;
    end
  endtask

  function automatic logic [31:0] out_of(input int ch);
    case (ch)
      0:       return {29'b0, pre0};
      1:       return {20'b0, rld0};
      default: return {20'b0, win0};
    endcase
  endfunction

  task automatic one_xfer(input int ch, input logic [31:0] d);
    int n;
    logic [31:0] mask;
    mask = (ch == 0) ? 32'h7 : 32'hFFF;
    bus_write(8'(ch * 4), d);
    chk("R3 flag set", {31'b0, rd0[ch]}, 32'h1);
    wait_idle(n);
    vecs++;
    if (n > SLOW_LIMIT) begin
      errs++;
      $display("FAIL R4 latency: actual %0d expected <= %0d bus cycles", n, SLOW_LIMIT);
    end
    chk("R4 value applied", out_of(ch), d & mask);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    int n;
    bus_arst_n = 1'b0; lsi_arst_n = 1'b0;
    reg_addr = 8'h0C; reg_wr = 1'b0; reg_wdata = '0;
    #300;
    @(negedge bus_clk);
    bus_arst_n = 1'b1; lsi_arst_n = 1'b1;
    #1500;
    @(negedge bus_clk); #1;

    // R1 reset state
    chk("R1 status", rd0, 32'h0);
    chk("R1 presc", {29'b0, pre0}, 32'h0);
    chk("R1 reload", {20'b0, rld0}, 32'hFFF);
    chk("R1 window", {20'b0, win0}, 32'hFFF);
    chk("R1 status nowin", rd1, 32'h0);

    // prescaler: exhaustive
    for (int v = 0; v < 8; v++) one_xfer(0, 32'hFFFF_FFF8 | 32'(v));

    // reload and window: walking ones/zeros, extremes, stride
    for (int ch = 1; ch <= 2; ch++) begin
      for (int b = 0; b < 12; b++) one_xfer(ch, 32'h1 << b);
      for (int b = 0; b < 12; b++) one_xfer(ch, ~(32'h1 << b));
      one_xfer(ch, 32'h0);
      one_xfer(ch, 32'hFFF);
      for (int k = 1; k <= 16; k++) one_xfer(ch, 32'((k * 32'h2AB) & 32'hFFF));
    end
    chk("R7 window nowin after writes", {20'b0, win1}, 32'hFFF);
    chk("R4 reload nowin tracks", {20'b0, rld1}, {20'b0, rld0});

    // R5 write while busy is ignored
    bus_write(8'h04, 32'h123);
    bus_write(8'h04, 32'h456);
    chk("R5 flag still set", {31'b0, rd0[1]}, 32'h1);
    wait_idle(n);
    chk("R5 first value kept", {20'b0, rld0}, 32'h123);
    one_xfer(1, 32'h456);
    chk("R5 later write accepted", {20'b0, rld0}, 32'h456);

    // R6 concurrent channels
    bus_write(8'h00, 32'h5);
    bus_write(8'h04, 32'hA5C);
    bus_write(8'h08, 32'h3E1);
    chk("R6 all flags set", rd0, 32'h7);
    chk("R7 nowin bit2 zero", rd1, 32'h3);
    reg_addr = 8'h04; #1;
    chk("R2 other offset reads zero", rd0, 32'h0);
    wait_idle(n);
    chk("R6 presc", {29'b0, pre0}, 32'h5);
    chk("R6 reload", {20'b0, rld0}, 32'hA5C);
    chk("R6 window", {20'b0, win0}, 32'h3E1);
    chk("R7 window nowin", {20'b0, win1}, 32'hFFF);

    // R2 write to status, R3 unmapped offset
    bus_write(8'h0C, 32'hFFFF_FFFF);
    chk("R2 status write ignored", rd0, 32'h0);
    bus_write(8'h10, 32'h7);
    chk("R3 unmapped sets no flag", rd0, 32'h0);
    repeat (100) @(negedge bus_clk);
    #1;
    chk("R2 outputs unchanged presc", {29'b0, pre0}, 32'h5);
    chk("R2 outputs unchanged reload", {20'b0, rld0}, 32'hA5C);

    // R7 window write on instance without the channel
    bus_write(8'h08, 32'h000);
    chk("R7 nowin flag", rd1, 32'h0);
    wait_idle(n);
    chk("R7 nowin window stays", {20'b0, win1}, 32'hFFF);
    chk("R4 window with channel", {20'b0, win0}, 32'h000);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule